// File: doc/BRIEF.md
# Coprocessor Transfer Address Sequencer

This block produces the memory address stream for a load or store that moves data between memory and a coprocessor register. When an instruction is launched, the block forms a byte offset from an 8-bit immediate counted in words. It adds that offset to a base register value or subtracts it, according to a direction bit. A pre/post select decides whether the first address uses the adjusted value or the unmodified base.

From the first word onward the block steps upward by one word per cycle. The length of the burst is not known in advance: the coprocessor raises a last-word signal on the final word, and the sequencer stops there. A hard cap ends a burst that runs past the maximum word count and flags the overrun.

If the coprocessor refuses the instruction, the block issues an undefined-instruction trap and makes no memory access. The long/short length select is held stable towards the coprocessor for the whole burst. Interrupt acknowledgement is blocked while the burst runs. When the burst completes and write-back was requested, the adjusted base is presented once.

Top module: `cpx_addr_seq`

## Requirements
- R1: The byte offset is the 8-bit immediate multiplied by four. It is added to the base when `dir_up`=1 and subtracted from the base when `dir_up`=0, modulo 2^AW.
- R2: With `pre_idx`=1 the first address is the adjusted base (base plus or minus the offset). With `pre_idx`=0 the first address is the base itself. The first address appears on `mem_addr` with `mem_req`=1 in the cycle after the accepted `start`.
- R3: Each further word address is the previous address plus 4, whatever the value of `dir_up`.
- R4: The word in which `cp_last`=1 is the final word, and `mem_req` is 0 in the following cycle.
- R5: `cp_long` equals the `long_sel` value captured with the accepted `start` for the whole burst.
- R6: A `start` while idle with `cp_accept`=0 makes `undef_trap` 1 for exactly the next cycle, and no memory request is made.
- R7: The two low bits of `mem_addr` are always 0. Base bits [1:0] are ignored when addressing.
- R8: `irq_ack` is 0 in every cycle with `mem_req`=1. When idle, `irq_ack` follows `irq_req`.
- R9: In the cycle after the final word, `wb_valid` is 1 only if `wb_req` was 1 at launch. `wb_addr` then equals base plus or minus the offset, with the base's low bits kept. `wb_valid` is 0 in all other cycles.
- R10: A burst never exceeds MAX_WORDS (16) words. If word 16 passes without `cp_last`, the burst ends and `len_err` is 1 for one cycle. Otherwise `len_err` is 0.
- R11: `start` and its operand inputs are ignored while a burst is in progress. The running address sequence is not disturbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse for one transfer instruction |
| base | input | AW | Base register value |
| imm_off | input | 8 | Word offset immediate |
| dir_up | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_idx | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Request base write-back |
| long_sel | input | 1 | Long/short length select for the coprocessor |
| cp_accept | input | 1 | Coprocessor accepts the instruction (sampled with start) |
| cp_last | input | 1 | Coprocessor marks the current word as the last |
| irq_req | input | 1 | Interrupt request |
| mem_req | output | 1 | Memory word access this cycle |
| mem_addr | output | AW | Word-aligned access address |
| cp_long | output | 1 | Captured long/short select |
| undef_trap | output | 1 | Undefined-instruction trap pulse |
| irq_ack | output | 1 | Interrupt acknowledge |
| wb_valid | output | 1 | Write-back value valid pulse |
| wb_addr | output | AW | Written-back base value |
| len_err | output | 1 | Burst cut at the length cap |

## Verification
The assertions assume that `cp_last` is meaningful only while `mem_req` is high, and that `start` is a single-cycle pulse. The stimulus drives `cp_last` only inside a burst, on the word chosen as final, and drops `start` after one cycle, except in the deliberate busy-time `start` pulses that probe R11. Random bursts draw lengths from 1 to 20 words, so some of them cross the 16-word cap. Bases with nonzero low bits, the extreme immediates 0 and 255, and rejected instructions are also driven as directed cases.

// File: rtl/cpx_seq_pkg.sv
package cpx_seq_pkg;
   typedef enum logic [0:0] {
      SEQ_IDLE = 1'b0,
      SEQ_XFER = 1'b1
   } seq_state_e;

   localparam int unsigned WORD_BYTES = 4;
endpackage

// File: rtl/cpx_first_addr.sv
module cpx_first_addr #(
   parameter int unsigned AW    = 32,
   parameter int unsigned OFF_W = 8
) (
   input  logic [AW-1:0]    base,
   input  logic [OFF_W-1:0] imm_off,
   input  logic             dir_up,
   input  logic             pre_idx,
   output logic [AW-1:0]    first_addr,
   output logic [AW-1:0]    adj_base
);
   localparam int unsigned PAD = AW - OFF_W - 2;

   if (AW < OFF_W + 3) begin : g_bad_width
      $error("cpx_first_addr: AW too small for scaled offset");
   end

   logic [AW-1:0] byte_off;
   logic [AW-1:0] pick;

   always_comb begin
      byte_off = {{PAD{1'b0}}, imm_off, 2'b00};
      adj_base = dir_up ? (base + byte_off) : (base - byte_off);
      pick     = pre_idx ? adj_base : base;
      first_addr = {pick[AW-1:2], 2'b00};
   end
endmodule

// File: rtl/cpx_burst_ctl.sv
module cpx_burst_ctl
   import cpx_seq_pkg::*;
#(
   parameter int unsigned AW        = 32,
   parameter int unsigned MAX_WORDS = 16,
   parameter bit          CAP_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          launch,
   input  logic [AW-1:0] first_addr,
   input  logic          cp_last,
   output logic          xfer,
   output logic [AW-1:0] addr,
   output logic          finish,
   output logic          cap_hit
);
   localparam int unsigned CW = $clog2(MAX_WORDS + 1);
   localparam logic [CW-1:0] CNT_MAX = CW'(MAX_WORDS);

   if (MAX_WORDS < 1) begin : g_bad_max
      $error("cpx_burst_ctl: MAX_WORDS must be at least 1");
   end

   seq_state_e    state_q;
   logic [CW-1:0] cnt_q;

   if (CAP_EN) begin : g_cap
      assign cap_hit = (cnt_q == CNT_MAX);
   end else begin : g_nocap
      assign cap_hit = 1'b0;
   end

   assign xfer   = (state_q == SEQ_XFER);
   assign finish = xfer & (cp_last | cap_hit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         addr    <= '0;
         cnt_q   <= '0;
      end else if (state_q == SEQ_IDLE) begin
         if (launch) begin
            state_q <= SEQ_XFER;
            addr    <= first_addr;
            cnt_q   <= CW'(1);
         end
      end else if (finish) begin
         state_q <= SEQ_IDLE;
      end else begin
         addr <= addr + AW'(WORD_BYTES);
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CW'(1);
      end
   end

   AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && !finish) |=> (addr == $past(addr) + AW'(WORD_BYTES))); // R3
   AST_FIRST_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer && launch) |=> (xfer && addr == $past(first_addr))); // R2
   AST_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> (addr[1:0] == 2'b00)); // R7
   AST_CAP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      xfer |-> (cnt_q <= CNT_MAX)); // R10
   AST_LAST_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer && cp_last) |=> !xfer); // R4
endmodule

// File: rtl/cpx_addr_seq.sv
module cpx_addr_seq #(
   parameter int unsigned AW        = 32,
   parameter int unsigned OFF_W     = 8,
   parameter int unsigned MAX_WORDS = 16,
   parameter bit          CAP_EN    = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] base,
   input  logic [7:0]    imm_off,
   input  logic          dir_up,
   input  logic          pre_idx,
   input  logic          wb_req,
   input  logic          long_sel,
   input  logic          cp_accept,
   input  logic          cp_last,
   input  logic          irq_req,
   output logic          mem_req,
   output logic [AW-1:0] mem_addr,
   output logic          cp_long,
   output logic          undef_trap,
   output logic          irq_ack,
   output logic          wb_valid,
   output logic [AW-1:0] wb_addr,
   output logic          len_err
);
   if (OFF_W != 8) begin : g_bad_off
      $error("cpx_addr_seq: immediate port is fixed at 8 bits");
   end

   logic [AW-1:0] first_addr, adj_base;
   logic          xfer, finish, cap_hit, launch, reject;
   logic [AW-1:0] wb_hold_q;
   logic          wb_en_q;

   cpx_first_addr #(.AW(AW), .OFF_W(OFF_W)) u_first (
      .base(base), .imm_off(imm_off), .dir_up(dir_up), .pre_idx(pre_idx),
      .first_addr(first_addr), .adj_base(adj_base)
   );

   cpx_burst_ctl #(.AW(AW), .MAX_WORDS(MAX_WORDS), .CAP_EN(CAP_EN)) u_ctl (
      .clk(clk), .rst_n(rst_n), .launch(launch), .first_addr(first_addr),
      .cp_last(cp_last), .xfer(xfer), .addr(mem_addr), .finish(finish),
      .cap_hit(cap_hit)
   );

   assign launch  = start & ~xfer & cp_accept;
   assign reject  = start & ~xfer & ~cp_accept;
   assign mem_req = xfer;
   assign irq_ack = irq_req & ~xfer;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         undef_trap <= 1'b0;
         wb_valid   <= 1'b0;
         wb_addr    <= '0;
         len_err    <= 1'b0;
         cp_long    <= 1'b0;
         wb_hold_q  <= '0;
         wb_en_q    <= 1'b0;
      end else begin
         undef_trap <= reject;
         wb_valid   <= finish & wb_en_q;
         len_err    <= finish & cap_hit & ~cp_last;
         if (finish) wb_addr <= wb_hold_q;
         if (launch) begin
            cp_long   <= long_sel;
            wb_hold_q <= adj_base;
            wb_en_q   <= wb_req;
         end
      end
   end

   AST_TRAP_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      undef_trap |-> !mem_req); // R6
   AST_IRQ_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !irq_ack); // R8
   AST_WB_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      wb_valid |-> ($past(mem_req) && !mem_req)); // R9
   AST_LONG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |-> $stable(cp_long)); // R5
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && start && !cp_last && !cap_hit) |=> (mem_req && mem_addr == $past(mem_addr) + AW'(4))); // R11
endmodule

// File: tb/sim_cpx_addr_seq.sv
module sim_cpx_addr_seq;
   localparam int AW = 32;
   localparam int MAXW = 16;

   logic clk = 0, rst_n = 0;
   logic start = 0, dir_up = 0, pre_idx = 0, wb_req = 0, long_sel = 0;
   logic cp_accept = 0, cp_last = 0, irq_req = 0;
   logic [AW-1:0] base = '0;
   logic [7:0] imm_off = '0;
   logic mem_req, cp_long, undef_trap, irq_ack, wb_valid, len_err;
   logic [AW-1:0] mem_addr, wb_addr;

   int checks = 0, errors = 0;
   bit done = 0;

   always #4 clk = ~clk;

   cpx_addr_seq u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .base(base), .imm_off(imm_off),
      .dir_up(dir_up), .pre_idx(pre_idx), .wb_req(wb_req), .long_sel(long_sel),
      .cp_accept(cp_accept), .cp_last(cp_last), .irq_req(irq_req),
      .mem_req(mem_req), .mem_addr(mem_addr), .cp_long(cp_long),
      .undef_trap(undef_trap), .irq_ack(irq_ack), .wb_valid(wb_valid),
      .wb_addr(wb_addr), .len_err(len_err)
   );

   function automatic logic [AW-1:0] f_adj(logic [AW-1:0] b, logic [7:0] i, logic up);
      logic [AW-1:0] o;
      o = AW'(i) * 4;
      return up ? b + o : b - o;
   endfunction

   function automatic logic [AW-1:0] f_first(logic [AW-1:0] b, logic [7:0] i, logic up, logic pre);
      logic [AW-1:0] a;
      a = pre ? f_adj(b, i, up) : b;
      return a & ~AW'(3);
   endfunction

   task automatic chk(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic run_xfer(input logic [AW-1:0] b, input logic [7:0] imm, input logic up,
                           input logic pre, input logic wb, input logic lng,
                           input logic acc, input int n, input bit junk);
      int words;
      logic [AW-1:0] first;
      @(negedge clk);
      base = b; imm_off = imm; dir_up = up; pre_idx = pre; wb_req = wb;
      long_sel = lng; cp_accept = acc; start = 1; cp_last = 0; irq_req = 1;
      first = f_first(b, imm, up, pre);
      words = (n > MAXW) ? MAXW : n;
      @(negedge clk);
      start = 0; cp_accept = 0;
      if (!acc) begin
         chk("R6 trap", undef_trap, 1);
         chk("R6 no access", mem_req, 0);
         @(negedge clk);
         chk("R6 trap one cycle", undef_trap, 0);
         chk("R6 still idle", mem_req, 0);
         return;
      end
      chk("R6 no trap when accepted", undef_trap, 0);
      for (int i = 1; i <= words; i++) begin
         chk("R4 request active", mem_req, 1);
         chk("R1 R2 R3 R7 address", mem_addr, first + AW'(4 * (i - 1)));
         chk("R8 irq held", irq_ack, 0);
         chk("R5 long select", cp_long, lng);
         chk("R9 no early wb", wb_valid, 0);
         if (junk) begin
            start = 1; cp_accept = 1; base = $urandom; imm_off = $urandom;
            pre_idx = $urandom; dir_up = $urandom; long_sel = ~lng; wb_req = ~wb;
         end
         cp_last = (i == n);
         @(negedge clk);
      end
      start = 0; cp_last = 0; cp_accept = 0;
      chk("R4 stop after last", mem_req, 0);
      chk("R9 wb valid", wb_valid, wb);
      if (wb) chk("R9 wb value", wb_addr, f_adj(b, imm, up));
      chk("R10 length error", len_err, (n > MAXW));
      chk("R8 irq ack when idle", irq_ack, 1);
      if (junk) chk("R11 busy start ignored", undef_trap, 0);
      @(negedge clk);
      chk("R9 wb pulse ends", wb_valid, 0);
      chk("R10 err pulse ends", len_err, 0);
      chk("R11 no stray launch", mem_req, 0);
   endtask

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      chk("R4 reset no request", mem_req, 0);
      chk("R6 reset no trap", undef_trap, 0);
      chk("R9 reset no wb", wb_valid, 0);
      chk("R10 reset no err", len_err, 0);
      rst_n = 1;
      // directed corners
      run_xfer(32'h0000_1003, 8'd0,   1, 1, 1, 0, 1, 1, 0);   // R7 unaligned base, zero offset
      run_xfer(32'h0000_2000, 8'd255, 1, 1, 1, 1, 1, 3, 0);   // R1 max offset up, pre
      run_xfer(32'h0000_2000, 8'd255, 0, 1, 1, 0, 1, 3, 0);   // R1 down
      run_xfer(32'h0000_0010, 8'd8,   0, 0, 1, 1, 1, 4, 0);   // R2 post: first = base, R3 up
      run_xfer(32'h0000_0004, 8'd4,   0, 1, 1, 0, 1, 2, 0);   // R1 wraps below zero
      run_xfer(32'hFFFF_FFF8, 8'd1,   1, 0, 0, 0, 1, 3, 0);   // R3 wraps, R9 no wb
      run_xfer(32'h0000_4000, 8'd2,   1, 1, 1, 0, 0, 1, 0);   // R6 reject
      run_xfer(32'h0000_5000, 8'd3,   1, 1, 1, 1, 1, 16, 0);  // R10 exactly 16
      run_xfer(32'h0000_6001, 8'd5,   0, 0, 1, 0, 1, 20, 0);  // R10 overrun
      run_xfer(32'h0000_7000, 8'd6,   1, 0, 1, 1, 1, 5, 1);   // R11 busy starts
      // constrained random
      for (int k = 0; k < 60; k++) begin
         run_xfer($urandom, 8'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
                  1'($urandom), ($urandom_range(0, 9) != 0), $urandom_range(1, 20),
                  1'($urandom));
      end
      done = 1;
   end

   initial begin
      fork
         begin wait (done); end
         begin
            repeat (100000) @(posedge clk);
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
         end
      join_any
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule